// File: doc/BRIEF.md
# Maskable Interrupt and Serial Bit Port

This block sits beside a processor core. It adds four interrupt inputs to an existing single-line request and acknowledge scheme, and it adds a one-bit serial input and a one-bit serial output. The core reaches the block through two accumulator instructions. A write instruction delivers a control byte that can update the interrupt masks, clear a latched edge request and set the serial output bit. A read instruction returns a status byte that holds the masks, the global interrupt enable, the pending maskable requests and the sampled serial input.

Among the active requests that are allowed through, the block picks the single highest-priority one. It presents that request to the core together with a vector index. When the core accepts a request, the global enable is cleared. If the accepted request is the legacy line, the acknowledge is passed back out to that line. Vector fetch sequencing and instruction decoding stay in the core.

Top module: `irq_serial_port`

## Requirements
- R1: After reset the status byte is 0x07: all three masks are set and the global enable is 0. No request is presented, and the serial output is 0.
- R2: A control write with bit 3 set loads bits 2:0 into the masks, where 1 means masked. A control write with bit 3 clear leaves the masks unchanged.
- R3: A control write with bit 6 set loads bit 7 into the serial output, starting on the next cycle. Without such a write the serial output holds its value.
- R4: Status byte layout: bits 2:0 are the masks, bit 3 is the global enable, and bits 6:4 are the pending flags for maskable inputs 2..0. Bit 7 is the serial input, seen two cycles after it is driven.
- R5: A non-maskable request is presented with vector 4. It needs a latched rising edge on its input while that input is still high. Masks and the global enable do not affect it. Acceptance clears the latch, so a new rising edge is needed before it is presented again.
- R6: Maskable input 2 is latched on its rising edge and stays pending after the input falls. It is cleared only by acceptance of vector 3 or by a control write with bit 4 set.
- R7: Maskable inputs 1 and 0 are level-sensitive. Their pending flags follow the inputs in the same cycle.
- R8: Maskable requests and the legacy request are presented only when the global enable is 1 and, for maskable inputs, the mask bit is 0.
- R9: Priority runs from highest to lowest: non-maskable (vector 4), then maskable input 2 (vector 3), input 1 (vector 2), input 0 (vector 1), and last the legacy request (vector 0). Only one vector is presented at a time.
- R10: Acceptance, which is ack_i while req_o is high, clears the global enable and takes priority over a set. legacy_ack_o is high only when vector 0 is accepted.
- R11: ie_set_i sets the global enable and ie_clr_i clears it. When both are high, clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Control byte write strobe |
| wr_data_i | input | 8 | Control byte from the accumulator |
| rd_data_o | output | 8 | Status byte to the accumulator |
| ie_set_i | input | 1 | Set global interrupt enable |
| ie_clr_i | input | 1 | Clear global interrupt enable |
| nmi_i | input | 1 | Non-maskable interrupt input |
| irq_i | input | 3 | Maskable interrupt inputs; index 2 is edge-latched |
| legacy_req_i | input | 1 | Legacy interrupt request |
| legacy_ack_o | output | 1 | Legacy acknowledge, passed through on acceptance |
| req_o | output | 1 | Interrupt request to the core |
| vec_o | output | 3 | Vector index of the presented request |
| ack_i | input | 1 | Core accepts the presented request |
| sin_i | input | 1 | Serial data input |
| sout_o | output | 1 | Serial data output |

## Verification
The requests are layered one at a time: first the legacy request alone, then level input 0 and level input 1 added on top, then a short pulse on the edge input. Each new request must take the vector from the previous one. Masking the edge input while it is latched separates a masked request from a cleared one, and the clear bit then separates the two. The non-maskable input is tested in several ways: while it is held high after acceptance, on a re-raised edge with the enable off, and while it is dropped low with its latch still set. These cases tell apart edge sensitivity, level sensitivity and independence from the enable. Control writes with their update-enable bits clear show whether the masks and serial output ignore them.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  localparam int DATA_W = 8;
  localparam int N_MASK = 3;
  localparam int VEC_W  = 3;

  // control byte fields
  localparam int CTL_MASK_EN  = 3;
  localparam int CTL_CLR_EDGE = 4;
  localparam int CTL_SOUT_EN  = 6;
  localparam int CTL_SOUT_VAL = 7;

  // status byte fields
  localparam int ST_IE      = 3;
  localparam int ST_PEND_LO = 4;
  localparam int ST_SIN     = 7;

  typedef enum logic [VEC_W-1:0] {
    VEC_LEGACY = 3'd0,
    VEC_IRQ0   = 3'd1,
    VEC_IRQ1   = 3'd2,
    VEC_IRQ2   = 3'd3,
    VEC_NMI    = 3'd4
  } vec_t;
endpackage

// File: rtl/irqp_sync.sv
module irqp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqp_edge_latch.sv
module irqp_edge_latch #(
  parameter bit LEVEL_QUAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, lat_q, rise;

  assign rise = sig_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= sig_i;
      // a fresh edge wins over a clear in the same cycle
      if (rise)       lat_q <= 1'b1;
      else if (clr_i) lat_q <= 1'b0;
    end
  end

  generate
    if (LEVEL_QUAL) begin : g_qual
      assign pend_o = lat_q & sig_i;
    end else begin : g_plain
      assign pend_o = lat_q;
    end
  endgenerate
endmodule

// File: rtl/irqp_prio.sv
module irqp_prio
  import irqp_pkg::*;
(
  input  logic              nmi_i,
  input  logic [N_MASK-1:0] mreq_i,
  input  logic              legacy_i,
  output logic              req_o,
  output vec_t              vec_o
);
  always_comb begin
    req_o = 1'b0;
    vec_o = VEC_LEGACY;
    if (nmi_i) begin
      req_o = 1'b1;
      vec_o = VEC_NMI;
    end
    for (int i = N_MASK-1; i >= 0; i--) begin
      if (!req_o && mreq_i[i]) begin
        req_o = 1'b1;
        vec_o = vec_t'(VEC_W'(i + 1));
      end
    end
    if (!req_o && legacy_i) begin
      req_o = 1'b1;
      vec_o = VEC_LEGACY;
    end
  end
endmodule

// File: rtl/irq_serial_port.sv
module irq_serial_port
  import irqp_pkg::*;
#(
  parameter int SIN_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              nmi_i,
  input  logic [N_MASK-1:0] irq_i,
  input  logic              legacy_req_i,
  output logic              legacy_ack_o,
  output logic              req_o,
  output logic [VEC_W-1:0]  vec_o,
  input  logic              ack_i,
  input  logic              sin_i,
  output logic              sout_o
);
  logic [N_MASK-1:0] mask_q;
  logic              ie_q, sout_q;
  logic              sin_s;
  logic              nmi_pend, edge_pend;
  logic [N_MASK-1:0] pend, mreq;
  logic              accept, edge_clr, prio_req;
  vec_t              prio_vec;

  assign accept = ack_i & req_o;

  irqp_edge_latch #(.LEVEL_QUAL(1'b1)) u_nmi (
    .clk_i (clk_i), .rst_ni (rst_ni), .sig_i (nmi_i),
    .clr_i (accept && prio_vec == VEC_NMI), .pend_o (nmi_pend)
  );

  assign edge_clr = (wr_en_i & wr_data_i[CTL_CLR_EDGE]) |
                    (accept && prio_vec == VEC_IRQ2);

  irqp_edge_latch #(.LEVEL_QUAL(1'b0)) u_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .sig_i (irq_i[N_MASK-1]),
    .clr_i (edge_clr), .pend_o (edge_pend)
  );

  irqp_sync #(.STAGES(SIN_STAGES)) u_sin (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (sin_i), .q_o (sin_s)
  );

  assign pend = {edge_pend, irq_i[N_MASK-2:0]};
  assign mreq = pend & ~mask_q & {N_MASK{ie_q}};

  irqp_prio u_prio (
    .nmi_i (nmi_pend), .mreq_i (mreq), .legacy_i (legacy_req_i & ie_q),
    .req_o (prio_req), .vec_o (prio_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
      sout_q <= 1'b0;
    end else begin
      if (wr_en_i && wr_data_i[CTL_MASK_EN]) mask_q <= wr_data_i[N_MASK-1:0];
      if (wr_en_i && wr_data_i[CTL_SOUT_EN]) sout_q <= wr_data_i[CTL_SOUT_VAL];
      if (accept || ie_clr_i) ie_q <= 1'b0;
      else if (ie_set_i)      ie_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[N_MASK-1:0] = mask_q;
    rd_data_o[ST_IE] = ie_q;
    rd_data_o[ST_PEND_LO +: N_MASK] = pend;
    rd_data_o[ST_SIN] = sin_s;
  end

  assign req_o        = prio_req;
  assign vec_o        = prio_vec;
  assign legacy_ack_o = accept && prio_vec == VEC_LEGACY;
  assign sout_o       = sout_q;
endmodule

// File: rtl/irqp_chk.sv
module irqp_chk
  import irqp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ack_i,
  input logic              req_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [N_MASK-1:0] irq_i,
  input logic              legacy_ack_o,
  input logic              sout_o
);
  // R8
  ie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && vec_o != VEC_NMI |-> rd_data_o[ST_IE]);

  // R10
  accept_clears_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && req_o |=> !rd_data_o[ST_IE]);

  // R10
  legacy_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy_ack_o |-> ack_i && req_o && vec_o == VEC_LEGACY);

  // R9
  legacy_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && vec_o == VEC_LEGACY |-> (irq_i[1:0] & ~rd_data_o[1:0]) == 2'b00);

  // R3
  sout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(sout_o));

  // R6
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[ST_PEND_LO+2] && !(wr_en_i && wr_data_i[CTL_CLR_EDGE]) &&
    !(ack_i && req_o && vec_o == VEC_IRQ2) |=> rd_data_o[ST_PEND_LO+2]);
endmodule

bind irq_serial_port irqp_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .wr_en_i (wr_en_i), .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o), .ack_i (ack_i), .req_o (req_o), .vec_o (vec_o),
  .irq_i (irq_i), .legacy_ack_o (legacy_ack_o), .sout_o (sout_o)
);

// File: tb/sim_irq_serial_port.sv
module sim_irq_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ie_set = 1'b0, ie_clr = 1'b0;
  logic       nmi = 1'b0;
  logic [2:0] irq = '0;
  logic       legacy_req = 1'b0;
  logic       legacy_ack;
  logic       req;
  logic [2:0] vec;
  logic       ack = 1'b0;
  logic       sin = 1'b0;
  logic       sout;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    string      rq;
    logic [7:0] st;
    logic       req;
    logic [2:0] vec;
    logic       sout;
    logic       lack;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  irq_serial_port u0 (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_data_i (wr_data),
    .rd_data_o (rd_data), .ie_set_i (ie_set), .ie_clr_i (ie_clr), .nmi_i (nmi),
    .irq_i (irq), .legacy_req_i (legacy_req), .legacy_ack_o (legacy_ack),
    .req_o (req), .vec_o (vec), .ack_i (ack), .sin_i (sin), .sout_o (sout)
  );

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      total++;
      if (rd_data !== e.st || req !== e.req || (e.req && vec !== e.vec) ||
          sout !== e.sout || legacy_ack !== e.lack) begin
        bad++;
        $display("FAIL %s: st=%h req=%b vec=%0d sout=%b lack=%b exp st=%h req=%b vec=%0d sout=%b lack=%b",
                 e.rq, rd_data, req, vec, sout, legacy_ack,
                 e.st, e.req, e.vec, e.sout, e.lack);
      end
    end
  end

  task automatic go();
    @(posedge clk);
    #1;
    wr_en = 1'b0; ie_set = 1'b0; ie_clr = 1'b0; ack = 1'b0;
  endtask

  task automatic expect_item(string rq, logic [7:0] st, logic r, logic [2:0] v,
                             logic so, logic la);
    item_t e;
    e.rq = rq; e.st = st; e.req = r; e.vec = v; e.sout = so; e.lack = la;
    q.push_back(e);
  endtask

  initial begin
    #(5 * 2000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    go(); expect_item("R1 reset", 8'h07, 0, 0, 0, 0);
    go(); wr_en = 1; wr_data = 8'hC0;
          expect_item("R3 before update", 8'h07, 0, 0, 0, 0);
    go(); wr_en = 1; wr_data = 8'h00;
          expect_item("R3 sout set", 8'h07, 0, 0, 1, 0);
    go(); ie_set = 1;
          expect_item("R2 mask kept without enable bit", 8'h07, 0, 0, 1, 0);
    go(); legacy_req = 1; ack = 1;
          expect_item("R11 R10 legacy accept", 8'h0F, 1, 0, 1, 1);
    go(); expect_item("R10 ie cleared by accept", 8'h07, 0, 0, 1, 0);
    go(); ie_set = 1; wr_en = 1; wr_data = 8'h08;
          expect_item("R8 legacy blocked ie=0", 8'h07, 0, 0, 1, 0);
    go(); irq[0] = 1;
          expect_item("R9 R7 irq0 over legacy", 8'h18, 1, 1, 1, 0);
    go(); irq[1] = 1;
          expect_item("R9 irq1 over irq0", 8'h38, 1, 2, 1, 0);
    go(); sin = 1; irq[2] = 1;
          expect_item("R6 edge not yet latched", 8'h38, 1, 2, 1, 0);
    go(); irq[2] = 0;
          expect_item("R6 edge latched after fall", 8'h78, 1, 3, 1, 0);
    go(); wr_en = 1; wr_data = 8'h0C;
          expect_item("R4 serial input seen", 8'hF8, 1, 3, 1, 0);
    go(); wr_en = 1; wr_data = 8'h10;
          expect_item("R8 R2 masked edge still pending", 8'hFC, 1, 2, 1, 0);
    go(); nmi = 1;
          expect_item("R6 edge cleared by control", 8'hBC, 1, 2, 1, 0);
    go(); ack = 1;
          expect_item("R5 nmi wins", 8'hBC, 1, 4, 1, 0);
    go(); expect_item("R5 nmi needs new edge", 8'hB4, 0, 0, 1, 0);
    go(); nmi = 0;
          expect_item("R5 nmi low", 8'hB4, 0, 0, 1, 0);
    go(); nmi = 1;
          expect_item("R5 nmi edge pending latch", 8'hB4, 0, 0, 1, 0);
    go(); expect_item("R5 nmi ignores ie and masks", 8'hB4, 1, 4, 1, 0);
    go(); nmi = 0;
          expect_item("R5 nmi needs level", 8'hB4, 0, 0, 1, 0);
    go(); nmi = 1;
          expect_item("R5 nmi latch held", 8'hB4, 1, 4, 1, 0);
    go(); ack = 1;
          expect_item("R10 no legacy ack for nmi", 8'hB4, 1, 4, 1, 0);
    go(); nmi = 0; ie_set = 1;
          expect_item("R5 nmi cleared", 8'hB4, 0, 0, 1, 0);
    go(); ie_clr = 1; ie_set = 1;
          expect_item("R11 ie set", 8'hBC, 1, 2, 1, 0);
    go(); expect_item("R11 clear wins", 8'hB4, 0, 0, 1, 0);
    go(); go();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule